// File: doc/BRIEF.md
# Multi-View Conversion Result Table

This block stores the results of an analog-to-digital conversion sequencer. It holds one 10-bit result for each of 64 command slots. When the conversion engine finishes the conversion ordered by slot N, it writes the result into entry N through a dedicated write port.

A 16-bit host port can read and write the same entries through three address windows. Each window shows the stored value in a different bit alignment:

- right-justified, unsigned;
- left-justified with the top bit flipped, which gives a half-scale-offset two's-complement number;
- left-justified, unsigned.

Host writes are always taken as right-justified, whichever window is used.

Host reads have one cycle of latency. The read data comes from a register, and a valid strobe marks it. A small state machine drives the strobe. It has two states:

- `ST_IDLE`: no response is pending.
- `ST_RESP`: the read data register holds fresh data.

Its transitions:

- **issue**: IDLE to RESP when a read is requested.
- **chain**: RESP to RESP when another read arrives.
- **drain**: RESP to IDLE when no read arrives.
- **stay**: IDLE to IDLE.

Top module: `conv_result_table`

## Requirements
- R1: An engine write with `eng_wr_en` high stores `eng_data` into entry `eng_slot`. A read issued in the next cycle or later returns that value.
- R2: `host_rd_valid` is high exactly in the cycle after a cycle with `host_rd_en` high. `host_rdata` is updated on that same edge and holds its value when no read is issued.
- R3: Window code `host_addr[7:6]` = 00 reads the entry in bits 9:0, with bits 15:10 zero.
- R4: Window code 01 reads the entry in bits 15:6, with stored bit 9 inverted in bit 15 and bits 5:0 zero.
- R5: Window code 10 reads the entry in bits 15:6 without inversion, with bits 5:0 zero.
- R6: A host write (`host_wr_en`) through window 00, 01 or 10 stores `host_wdata[9:0]` into entry `host_addr[5:0]`. Bits 15:10 of the bus word have no effect.
- R7: Window code 11 reads as 0x0000, and host writes through it change no entry.
- R8: A host write and an engine write to the same entry in the same cycle:
  - the entry takes the engine value;
  - `wr_collision` is high for exactly the following cycle.
  
  `wr_collision` is low in every other cycle.
- R9: Reset clears every entry to zero, so a window 01 read returns 0x8000. `host_rdata`, `host_rd_valid` and `wr_collision` are zero after reset.
- R10: A read in the same cycle as a write to the same entry returns the value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eng_wr_en | input | 1 | Engine result write strobe |
| eng_slot | input | 6 | Command slot and entry index of the result |
| eng_data | input | 10 | Conversion result |
| host_rd_en | input | 1 | Host read request |
| host_wr_en | input | 1 | Host write request |
| host_addr | input | 8 | Word address: bits 7:6 select the window, bits 5:0 select the entry |
| host_wdata | input | 16 | Host write data, right-justified |
| host_rdata | output | 16 | Registered read data in the selected alignment |
| host_rd_valid | output | 1 | Read data valid, one cycle after the request |
| wr_collision | output | 1 | Pulse after a same-entry host and engine write |

## Verification
The bench builds the block with its default parameters:

- 64 entries;
- 10-bit results;
- a 16-bit bus, which leaves six padding bits in every window.

These values put the full index range within reach, from entry 0 through entry 63. They also cover the sign flip at bit 9 for the values 0x000, 0x200 and 0x3FF.

At the same parameters, a random phase mixes engine writes, host writes through all four window codes, and reads. It forces same-slot collisions and reads of entries that are being written in the same cycle.

// File: rtl/crt_pkg.sv
package crt_pkg;

    // Width of the window-select field of the host word address
    localparam int VIEW_W = 2;

    // Window code carried in the top address bits
    typedef enum logic [VIEW_W-1:0] {
        VIEW_RJU  = 2'b00,   // right-justified, unsigned
        VIEW_LJS  = 2'b01,   // left-justified, sign-flipped
        VIEW_LJU  = 2'b10,   // left-justified, unsigned
        VIEW_NONE = 2'b11    // unmapped
    } view_e;

    // Read response state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } rd_state_e;

endpackage

// File: rtl/crt_decode.sv
module crt_decode
    import crt_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [VIEW_W+IDX_W-1:0] addr,
    output view_e                   view,
    output logic [IDX_W-1:0]        entry,
    output logic                    mapped
);

    localparam int ADDR_W = VIEW_W + IDX_W;

    always_comb begin
        view   = view_e'(addr[ADDR_W-1 -: VIEW_W]);
        entry  = addr[IDX_W-1:0];
        mapped = (view != VIEW_NONE);
    end

endmodule

// File: rtl/crt_store.sv
module crt_store #(
    parameter int ENTRIES = 64,
    parameter int RES_W   = 10,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eng_we,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [RES_W-1:0] eng_d,
    input  logic             host_we,
    input  logic [IDX_W-1:0] host_idx,
    input  logic [RES_W-1:0] host_d,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RES_W-1:0] rd_word,
    output logic             clash
);

    logic [RES_W-1:0] mem [ENTRIES];

    // Same-entry write from both ports: the engine keeps the entry
    always_comb clash = host_we && eng_we && (host_idx == eng_idx);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem[i] <= '0;
            end
        end else begin
            if (host_we && !clash) begin
                mem[host_idx] <= host_d;
            end
            if (eng_we) begin
                mem[eng_idx] <= eng_d;
            end
        end
    end

    // Read reflects contents before this cycle's writes
    always_comb rd_word = mem[rd_idx];

endmodule

// File: rtl/crt_align.sv
module crt_align
    import crt_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int BUS_W = 16,
    localparam int PAD  = BUS_W - RES_W
) (
    input  logic [RES_W-1:0] value,
    input  view_e            view,
    output logic [BUS_W-1:0] word
);

    always_comb begin
        unique case (view)
            VIEW_RJU: word = {{PAD{1'b0}}, value};
            VIEW_LJS: word = {~value[RES_W-1], value[RES_W-2:0], {PAD{1'b0}}};
            VIEW_LJU: word = {value, {PAD{1'b0}}};
            default:  word = '0;
        endcase
    end

endmodule

// File: rtl/conv_result_table.sv
module conv_result_table
    import crt_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int RES_W   = 10,
    parameter int BUS_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int ADDR_W = VIEW_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_wr_en,
    input  logic [IDX_W-1:0]  eng_slot,
    input  logic [RES_W-1:0]  eng_data,
    input  logic              host_rd_en,
    input  logic              host_wr_en,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [BUS_W-1:0]  host_wdata,
    output logic [BUS_W-1:0]  host_rdata,
    output logic              host_rd_valid,
    output logic              wr_collision
);

    view_e            view;
    logic [IDX_W-1:0] entry;
    logic             mapped;
    logic [RES_W-1:0] rd_word;
    logic [BUS_W-1:0] aligned;
    logic             clash;
    rd_state_e        state_q, state_d;
    logic [BUS_W-1:0] rdata_q;
    logic             coll_q;

    crt_decode #(.IDX_W(IDX_W)) u_decode (
        .addr   (host_addr),
        .view   (view),
        .entry  (entry),
        .mapped (mapped)
    );

    crt_store #(.ENTRIES(ENTRIES), .RES_W(RES_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .eng_we   (eng_wr_en),
        .eng_idx  (eng_slot),
        .eng_d    (eng_data),
        .host_we  (host_wr_en && mapped),
        .host_idx (entry),
        .host_d   (host_wdata[RES_W-1:0]),
        .rd_idx   (entry),
        .rd_word  (rd_word),
        .clash    (clash)
    );

    crt_align #(.RES_W(RES_W), .BUS_W(BUS_W)) u_align (
        .value (rd_word),
        .view  (view),
        .word  (aligned)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: issue / chain / drain / stay
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = host_rd_en ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = host_rd_en ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Data and collision registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            coll_q  <= 1'b0;
        end else begin
            if (host_rd_en) rdata_q <= aligned;
            coll_q <= clash;
        end
    end

    // Outputs
    always_comb begin
        host_rd_valid = (state_q == ST_RESP);
        host_rdata    = rdata_q;
        wr_collision  = coll_q;
    end

endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
    parameter int RES_W = 10,
    parameter int BUS_W = 16,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eng_wr_en,
    input logic [IDX_W-1:0] eng_slot,
    input logic             host_rd_en,
    input logic             host_wr_en,
    input logic [IDX_W+1:0] host_addr,
    input logic [BUS_W-1:0] host_rdata,
    input logic             host_rd_valid,
    input logic             wr_collision
);

    localparam int PAD = BUS_W - RES_W;

    logic [1:0] win;
    logic       same_slot;

    always_comb begin
        win       = host_addr[IDX_W+1:IDX_W];
        same_slot = host_wr_en && eng_wr_en && (win != 2'b11)
                    && (host_addr[IDX_W-1:0] == eng_slot);
    end

    p_valid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_en |=> host_rd_valid);

    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_en |=> !host_rd_valid);

    p_data_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd_en |=> $stable(host_rdata));

    p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && win == 2'b00) |=> (host_rdata[BUS_W-1:RES_W] == '0));

    p_lower_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && win == 2'b01) |=> (host_rdata[PAD-1:0] == '0));

    p_lower_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && win == 2'b10) |=> (host_rdata[PAD-1:0] == '0));

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_en && win == 2'b11) |=> (host_rdata == '0));

    p_collision_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        same_slot |=> wr_collision);

    p_no_false_collision_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !same_slot |=> !wr_collision);

endmodule

bind conv_result_table crt_checker #(
    .RES_W(RES_W), .BUS_W(BUS_W), .IDX_W(IDX_W)
) u_crt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .eng_wr_en     (eng_wr_en),
    .eng_slot      (eng_slot),
    .host_rd_en    (host_rd_en),
    .host_wr_en    (host_wr_en),
    .host_addr     (host_addr),
    .host_rdata    (host_rdata),
    .host_rd_valid (host_rd_valid),
    .wr_collision  (wr_collision)
);

// File: tb/test_conv_result_table.sv
`timescale 1ns/1ps
module test_conv_result_table;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        eng_wr_en = 1'b0;
    logic [5:0]  eng_slot = '0;
    logic [9:0]  eng_data = '0;
    logic        host_rd_en = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rd_valid;
    logic        wr_collision;

    int checks = 0;
    int fails  = 0;
    int model [64];
    int exp_rdata = 0;
    bit exp_valid = 0;
    bit exp_coll  = 0;
    bit finished  = 0;

    always #2 clk = ~clk;   // 250 MHz

    conv_result_table i_conv_result_table (
        .clk(clk), .rst_n(rst_n),
        .eng_wr_en(eng_wr_en), .eng_slot(eng_slot), .eng_data(eng_data),
        .host_rd_en(host_rd_en), .host_wr_en(host_wr_en),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rd_valid(host_rd_valid),
        .wr_collision(wr_collision)
    );

    // Expected bus word for a stored value seen through a window code
    function automatic int view_of(int v, int w);
        case (w)
            0: return v;
            1: return ((v ^ 512) * 64) & 16'hFFFF;
            2: return (v * 64) & 16'hFFFF;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update model, compare at next negedge
    task automatic cyc(bit rd, bit wr, int a, int wd, bit ew, int es, int ed,
                       string tag = "");
        int win = (a >> 6) & 3;
        int idx = a & 63;
        string t;
        host_rd_en = rd; host_wr_en = wr; host_addr = 8'(a); host_wdata = 16'(wd);
        eng_wr_en = ew; eng_slot = 6'(es); eng_data = 10'(ed);
        exp_valid = rd;
        exp_coll  = wr && ew && (win != 3) && (es == idx);
        if (rd) exp_rdata = view_of(model[idx], win);
        if (wr && win != 3) model[idx] = wd & 16'h3FF;
        if (ew) model[es] = ed;
        @(negedge clk);
        check("R2", int'(host_rd_valid), int'(exp_valid));
        check("R8", int'(wr_collision), int'(exp_coll));
        if (tag != "") t = tag;
        else if (win == 0) t = "R3";
        else if (win == 1) t = "R4";
        else if (win == 2) t = "R5";
        else t = "R7";
        check(t, int'(host_rdata), exp_rdata);
    endtask

    task automatic read_all_views(int idx, string tag = "");
        for (int w = 0; w < 4; w++) cyc(1, 0, w * 64 + idx, 0, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        for (int i = 0; i < 64; i++) model[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state of the outputs
        check("R9", int'(host_rdata), 0);
        check("R9", int'(host_rd_valid), 0);
        check("R9", int'(wr_collision), 0);
        // R9: every entry cleared, sign-flipped view reads 0x8000
        for (int i = 0; i < 64; i++) cyc(1, 0, 64 + i, 0, 0, 0, 0, "R9");
        // R1: engine writes of the corner values, read through every window
        cyc(0, 0, 0, 0, 1, 0, 'h000);
        cyc(0, 0, 0, 0, 1, 1, 'h200);
        cyc(0, 0, 0, 0, 1, 63, 'h3FF);
        cyc(0, 0, 0, 0, 1, 17, 'h155);
        read_all_views(0);
        read_all_views(1);
        read_all_views(63);
        read_all_views(17);
        cyc(1, 0, 17, 0, 0, 0, 0, "R1");
        // R6: host writes with junk above bit 9 through each mapped window
        cyc(0, 1, 0 * 64 + 5, 'hFC00 | 'h2AA, 0, 0, 0);
        cyc(0, 1, 1 * 64 + 6, 'hA800 | 'h3FF, 0, 0, 0);
        cyc(0, 1, 2 * 64 + 7, 'h5400 | 'h200, 0, 0, 0);
        cyc(1, 0, 5, 0, 0, 0, 0, "R6");
        cyc(1, 0, 6, 0, 0, 0, 0, "R6");
        cyc(1, 0, 7, 0, 0, 0, 0, "R6");
        read_all_views(6);
        // R7: write through window 11 is discarded
        cyc(0, 1, 3 * 64 + 5, 'h0011, 0, 0, 0, "R7");
        cyc(1, 0, 5, 0, 0, 0, 0, "R7");
        cyc(1, 0, 3 * 64 + 5, 0, 0, 0, 0, "R7");
        // R8: same-entry collision, engine wins
        cyc(0, 1, 64 + 9, 'h0123, 1, 9, 'h321, "R8");
        cyc(1, 0, 9, 0, 0, 0, 0, "R8");
        // different entries in the same cycle: both land, no pulse
        cyc(0, 1, 10, 'h0044, 1, 11, 'h055, "R8");
        cyc(1, 0, 10, 0, 0, 0, 0, "R8");
        cyc(1, 0, 11, 0, 0, 0, 0, "R8");
        // window 11 write plus engine to same slot: no pulse
        cyc(0, 1, 3 * 64 + 12, 'h0001, 1, 12, 'h0AA, "R8");
        // R10: read during write to the same entry returns old value
        cyc(1, 1, 13, 'h0077, 0, 0, 0, "R10");
        cyc(1, 0, 13, 0, 1, 13, 'h099, "R10");
        cyc(1, 0, 13, 0, 0, 0, 0, "R10");
        // R2: back-to-back reads and data held while idle
        cyc(1, 0, 2 * 64 + 63, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 0, 0, "R2");
        cyc(0, 0, 0, 0, 0, 0, 0, "R2");
        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                int'($urandom_range(0, 255)), int'($urandom_range(0, 65535)),
                1'($urandom_range(0, 1)), int'($urandom_range(0, 7)) * 8 + 1,
                int'($urandom_range(0, 1023)));
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule